// File: doc/BRIEF.md
# Predicated Vector Compaction Unit

This block filters one vector of single-precision floating-point lanes against a scalar limit and squeezes the survivors together. A lane survives when its mask bit is set and its value is strictly below the limit. The surviving lanes are moved down to the lowest lane positions in their original order. Every lane above them is cleared to zero. The block also reports how many lanes survived, so that a downstream store unit can advance its write offset by that amount.

A valid/ready handshake is used on both sides. One vector is accepted per cycle while the result side is not stalled, and the registered result appears on the cycle after acceptance. The lane count is a parameter, with 8 lanes by default. Each lane is 32 bits wide.

Top module: `vec_compact`

## Requirements
- R1: A lane is selected only when its bit in `src_mask` is 1 and its 32-bit value, read as IEEE-754 single precision (bit 31 sign, bits 30:23 exponent, bits 22:0 fraction), is strictly less than `src_limit`.
- R2: A NaN (exponent all ones with a non-zero fraction), whether in a lane or in the limit, never compares less. +0 and -0 compare equal, so neither is below the other.
- R3: Selected lanes appear in `dst_lanes` from lane 0 upward, in ascending order of their source lane index. Lane k occupies bits 32k+31 to 32k.
- R4: Every output lane at an index equal to or above `dst_count` is zero.
- R5: `dst_count` equals the number of selected lanes, from 0 to LANES.
- R6: A vector accepted on a clock edge (`src_valid` and `src_ready` both high) produces `dst_valid` high with its result after that same edge.
- R7: While `dst_valid` is high and `dst_ready` is low, `src_ready` is low and `dst_lanes` and `dst_count` hold their values. An input offered during this time is not taken.
- R8: While `rst_n` is low, `dst_valid` is 0, `dst_count` is 0 and `src_ready` is 1.
- R9: A lane whose mask bit is 0 has no effect on the result, even when its value is below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Input vector offered |
| src_ready | output | 1 | Input vector can be taken |
| src_lanes | input | LANES*32 | Input lanes, lane k in bits 32k+31:32k |
| src_mask | input | LANES | Governing mask, one bit per lane |
| src_limit | input | 32 | Single-precision limit |
| dst_valid | output | 1 | Result present |
| dst_ready | input | 1 | Result taken |
| dst_lanes | output | LANES*32 | Packed lanes, zero filled |
| dst_count | output | $clog2(LANES+1) | Number of selected lanes |

## Verification
Directed vectors cover the cases where the outcome is known in advance: every lane selected, which must give an identity copy, an empty mask, alternating masks, and a single survivor in the top lane that has to travel to lane 0. They also cover a NaN limit, NaN lanes, signed zeros and infinities, which separate a true floating-point ordering from an integer compare on the raw bits. A second set of cases puts values below the limit in masked-off lanes, which shows whether the mask gates the selection. Random vectors are then drawn from a pool that mixes ordinary values with these special values, so ties and sign mixes occur often. A stall sequence holds back the result side while a second vector is offered, and this shows whether the result is held and whether the extra vector is refused.

// File: rtl/vec_compact.sv
module vec_compact #(
  parameter int LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          src_valid,
  output logic                          src_ready,
  input  logic [LANES*32-1:0]           src_lanes,
  input  logic [LANES-1:0]              src_mask,
  input  logic [31:0]                   src_limit,
  output logic                          dst_valid,
  input  logic                          dst_ready,
  output logic [LANES*32-1:0]           dst_lanes,
  output logic [$clog2(LANES+1)-1:0]    dst_count
);
  localparam int EW = 32;
  localparam int CW = $clog2(LANES + 1);

  function automatic logic is_nan(input logic [EW-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic flt_lt(input logic [EW-1:0] a, input logic [EW-1:0] b);
    logic lt;
    if (is_nan(a) || is_nan(b))
      lt = 1'b0;
    else if (a[30:0] == 31'd0 && b[30:0] == 31'd0)
      lt = 1'b0;
    else
      case ({a[31], b[31]})
        2'b00:   lt = a[30:0] < b[30:0];
        2'b11:   lt = a[30:0] > b[30:0];
        2'b10:   lt = 1'b1;
        default: lt = 1'b0;
      endcase
    return lt;
  endfunction

  logic [LANES-1:0] sel;
  logic [CW-1:0]    pos [LANES+1];
  logic [EW-1:0]    packed_w [LANES];
  logic             take;

  assign pos[0]    = '0;
  assign src_ready = !dst_valid || dst_ready;
  assign take      = src_valid && src_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel[i]   = src_mask[i] && flt_lt(src_lanes[i*EW +: EW], src_limit);
    assign pos[i+1] = pos[i] + CW'(sel[i]);
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      packed_w[k] = '0;
      for (int i = k; i < LANES; i++)
        if (sel[i] && pos[i] == CW'(k))
          packed_w[k] = packed_w[k] | src_lanes[i*EW +: EW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_valid <= 1'b0;
      dst_count <= '0;
      dst_lanes <= '0;
    end else if (take) begin
      dst_valid <= 1'b1;
      dst_count <= pos[LANES];
      for (int k = 0; k < LANES; k++)
        dst_lanes[k*EW +: EW] <= packed_w[k];
    end else if (dst_ready) begin
      dst_valid <= 1'b0;
    end
  end
endmodule

module vec_compact_chk #(
  parameter int LANES = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       src_valid,
  input logic                       src_ready,
  input logic                       dst_valid,
  input logic                       dst_ready,
  input logic [LANES*32-1:0]        dst_lanes,
  input logic [$clog2(LANES+1)-1:0] dst_count
);
  localparam int CW = $clog2(LANES + 1);

  p_accept_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready |=> dst_valid);

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |-> !src_ready);

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(dst_lanes) && $stable(dst_count));

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> dst_count <= CW'(LANES));

  for (genvar k = 0; k < LANES; k++) begin : g_fill
    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && dst_count <= CW'(k) |-> dst_lanes[k*32 +: 32] == 32'd0);
  end
endmodule

bind vec_compact vec_compact_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_lanes(dst_lanes),
  .dst_count(dst_count)
);

// File: tb/tb_vec_compact.sv
module tb_vec_compact;
  localparam int LANES = 8;
  localparam int VW = LANES * 32;
  localparam int CW = $clog2(LANES + 1);

  logic clk = 0, rst_n = 0;
  logic src_valid = 0, dst_ready = 1;
  logic src_ready, dst_valid;
  logic [VW-1:0] src_lanes = '0, dst_lanes;
  logic [LANES-1:0] src_mask = '0;
  logic [31:0] src_limit = '0;
  logic [CW-1:0] dst_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_compact #(.LANES(LANES)) dut (.*);

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit nan_ref(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] key_ref(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic bit lt_ref(input logic [31:0] a, input logic [31:0] b);
    if (nan_ref(a) || nan_ref(b)) return 0;
    return key_ref(a) < key_ref(b);
  endfunction

  task automatic model(input logic [VW-1:0] v, input logic [LANES-1:0] m, input logic [31:0] t,
                       output logic [VW-1:0] ev, output logic [CW-1:0] ec);
    int n = 0;
    ev = '0;
    for (int i = 0; i < LANES; i++)
      if (m[i] && lt_ref(v[i*32 +: 32], t)) begin
        ev[n*32 +: 32] = v[i*32 +: 32];
        n++;
      end
    ec = CW'(n);
  endtask

  task automatic apply(input string req, input logic [VW-1:0] v, input logic [LANES-1:0] m,
                       input logic [31:0] t);
    logic [VW-1:0] ev;
    logic [CW-1:0] ec;
    model(v, m, t, ev, ec);
    @(negedge clk);
    src_lanes = v; src_mask = m; src_limit = t; src_valid = 1; dst_ready = 1;
    chk({req, " R8 ready"}, VW'(src_ready), VW'(1));
    @(negedge clk);
    src_valid = 0;
    chk({req, " R6 valid"}, VW'(dst_valid), VW'(1));
    chk({req, " R3/R4 lanes"}, dst_lanes, ev);
    chk({req, " R5 count"}, VW'(dst_count), VW'(ec));
  endtask

  function automatic logic [31:0] rnd_f();
    case ($urandom % 10)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7FC0_0001;
      3: return 32'h7F80_0000;
      4: return 32'hFF80_0000;
      default: return {1'($urandom), 8'(8'd124 + $urandom % 6), 23'($urandom % 4)};
    endcase
  endfunction

  function automatic logic [VW-1:0] splat(input logic [31:0] x);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*32 +: 32] = x;
    return r;
  endfunction

  function automatic logic [VW-1:0] ramp();
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*32 +: 32] = 32'h3F80_0000 + 32'(i);
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] va, vb, ea, eb, vr;
    logic [CW-1:0] ca, cb;
    void'($urandom(32'd20240813));
    @(negedge clk);
    chk("R8 reset valid", VW'(dst_valid), VW'(0));
    chk("R8 reset count", VW'(dst_count), VW'(0));
    chk("R8 reset ready", VW'(src_ready), VW'(1));
    @(negedge clk); rst_n = 1;

    apply("R1 all selected", ramp(), 8'hFF, 32'h4000_0000);
    apply("R5 empty mask", ramp(), 8'h00, 32'h4000_0000);
    apply("R3 alternating", ramp(), 8'hAA, 32'h4000_0000);
    apply("R3 alternating low", ramp(), 8'h55, 32'h4000_0000);
    vr = '0; vr[7*32 +: 32] = 32'hBF80_0000;
    apply("R3 top lane to lane0", vr, 8'h80, 32'h0000_0000);
    apply("R2 nan limit", ramp(), 8'hFF, 32'h7FC0_0000);
    apply("R2 nan lanes", splat(32'hFFC0_0000), 8'hFF, 32'h7F80_0000);
    apply("R2 neg zero vs pos zero", splat(32'h8000_0000), 8'hFF, 32'h0000_0000);
    apply("R2 pos zero vs neg zero", splat(32'h0000_0000), 8'hFF, 32'h8000_0000);
    apply("R1 negatives order", {32'hC000_0000, 32'hBF80_0000, 32'h3F80_0000, 32'hFF80_0000,
                                 32'h0000_0000, 32'hC040_0000, 32'h7F80_0000, 32'hBF00_0000},
          8'hFF, 32'hBF80_0000);
    apply("R9 masked lanes ignored", splat(32'hBF80_0000), 8'h00, 32'h3F80_0000);
    apply("R9 partial mask", ramp(), 8'h0F, 32'h7F80_0000);

    va = ramp(); vb = splat(32'hC000_0000);
    model(va, 8'h3C, 32'h7F80_0000, ea, ca);
    model(vb, 8'h81, 32'h0000_0000, eb, cb);
    @(negedge clk);
    dst_ready = 0; src_lanes = va; src_mask = 8'h3C; src_limit = 32'h7F80_0000; src_valid = 1;
    @(negedge clk);
    src_lanes = vb; src_mask = 8'h81; src_limit = 32'h0000_0000;
    chk("R7 ready low on stall", VW'(src_ready), VW'(0));
    chk("R7 stall lanes", dst_lanes, ea);
    @(negedge clk);
    chk("R7 held valid", VW'(dst_valid), VW'(1));
    chk("R7 held lanes", dst_lanes, ea);
    chk("R7 held count", VW'(dst_count), VW'(ca));
    dst_ready = 1;
    @(negedge clk);
    src_valid = 0;
    chk("R7 next lanes", dst_lanes, eb);
    chk("R7 next count", VW'(dst_count), VW'(cb));
    @(negedge clk);
    chk("R6 drains", VW'(dst_valid), VW'(0));

    for (int n = 0; n < 400; n++) begin
      logic [VW-1:0] rv;
      for (int i = 0; i < LANES; i++) rv[i*32 +: 32] = rnd_f();
      apply("R1 random", rv, LANES'($urandom), rnd_f());
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule